// File: doc/BRIEF.md
# Timer Tick Gate and Power-of-Four Prescaler

This block produces the counting enables for a bank of timer channels, one OS timer and one watchdog. It runs entirely in one system clock. Three parent time bases arrive as one-cycle tick strobes: the peripheral tick, the RTC tick and the external tick. For each clock slot the block picks one parent and divides its ticks by a power of four. A stop bit can hold the result off. Each slot drives a one-cycle tick-enable that a timer counter elsewhere uses as its count enable.

Software controls the block through a word-addressed synchronous register port. Three registers handle gating. A read-only status word shows which clocks are stopped. A stop-set register stops the clocks whose bits are written as 1. A stop-clear register restarts the clocks whose bits are written as 1. Each slot also has a control register that holds its parent select and prescale. A slot must be running before software changes its control register. The channel count `NUM_CH` (6 or 8) and the presence of the OS timer slot (`HAS_OST`) are parameters. An absent OS timer slot reads as 0 and never ticks.

Top module: `tmr_tick_gen`

## Requirements
- R1: After reset every present stop bit is 1. With eight channels and the OS timer, the status word at address 0 reads 0x0001_80FF. Every control register reads 0 and no tick-enable is asserted.
- R2: Each 1 bit written to address 1 (stop-set) stops one clock. Channel i uses bit i, the OS timer uses bit 15 and the watchdog uses bit 16. The status word shows 1 for a stopped clock. A stopped clock asserts no tick-enable, starting in the cycle after the write.
- R3: Each 1 bit written to address 2 (stop-clear) restarts one clock. A 0 bit written to address 1 or address 2 leaves that stop bit unchanged.
- R4: Bits [2:0] of a control register select the parent, one bit per parent. Bit 0 selects the peripheral tick, bit 1 the RTC tick and bit 2 the external tick. When more than one bit is set, the lowest set bit decides. Only ticks of the selected parent advance the slot.
- R5: Bits [5:3] of a control register hold a prescale value n. For n from 0 to 5 the slot emits one tick-enable per 4^n selected parent ticks. For n = 6 and n = 7 it emits one per 1024 ticks. Each tick-enable lasts one cycle. It is asserted in the cycle after the parent tick that completes the period.
- R6: A write to the control register of a stopped clock is discarded. The value read back stays the same.
- R7: An accepted control write clears the slot's divider, and so does a restart. The first tick-enable then arrives after a full period of selected parent ticks that occur after the write. A parent tick that arrives in the same cycle as the control write is not counted.
- R8: A running slot whose parent bits [2:0] are all 0 asserts no tick-enable.
- R9: Reads are registered: `reg_rdata` shows the data for an address in the cycle after `reg_addr` is presented. The data depends on the address:
  - address 0 gives the status word;
  - addresses 8+i (channel i), 16 (OS timer) and 17 (watchdog) give bits [5:0] of that control register, zero-extended;
  - every other address reads 0.
  Bits above bit 5 of a control write are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_pclk | input | 1 | Peripheral parent tick strobe |
| tick_rtc | input | 1 | RTC parent tick strobe |
| tick_ext | input | 1 | External parent tick strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| tick_ch | output | NUM_CH | Tick-enable per timer channel |
| tick_ost | output | 1 | OS timer tick-enable |
| tick_wdt | output | 1 | Watchdog tick-enable |

## Verification
The main dividing function is driven in four ways:
- Parent ticks present in every cycle at each prescale value. This separates the exact divide ratios, including the saturation of values 6 and 7.
- All three parents set at once with overlapping select bits. This tells lowest-bit priority apart from any other choice.
- Sparse and gapped tick patterns. These show that only the selected parent's ticks are counted.
- Control writes and restarts landing in the middle of a period. These separate a cleared divider from one that keeps its old phase.

A long seeded random mix of gating writes, control writes to all slots, reads and tick patterns is then compared cycle by cycle against a bench model.

// File: rtl/tmr_tick_pkg.sv
`timescale 1ns/1ps
package tmr_tick_pkg;

  localparam int unsigned REG_AW  = 5;
  localparam int unsigned REG_DW  = 32;
  localparam int unsigned STAT_IW = $clog2(REG_DW);
  localparam int unsigned PAR_W   = 3;
  localparam int unsigned PSC_W   = 3;
  localparam int unsigned PSC_MAX = 5;
  localparam int unsigned CNT_W   = 2 * PSC_MAX;

  // register addresses (word index)
  localparam logic [REG_AW-1:0] A_STATUS   = 5'd0;
  localparam logic [REG_AW-1:0] A_STOP_SET = 5'd1;
  localparam logic [REG_AW-1:0] A_STOP_CLR = 5'd2;
  localparam logic [REG_AW-1:0] A_CH_BASE  = 5'd8;
  localparam logic [REG_AW-1:0] A_OST_CTRL = 5'd16;
  localparam logic [REG_AW-1:0] A_WDT_CTRL = 5'd17;

  // stop bit positions of the two special slots
  localparam int unsigned BIT_OST = 15;
  localparam int unsigned BIT_WDT = 16;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic [PAR_W-1:0] par;
  } clk_ctrl_t;

  localparam int unsigned CTRL_W = $bits(clk_ctrl_t);

  // slot k: 0..nch-1 channels, nch OS timer, nch+1 watchdog
  function automatic logic [STAT_IW-1:0] stop_bit(input int unsigned k, input int unsigned nch);
    if (k < nch) return STAT_IW'(k);
    if (k == nch) return STAT_IW'(BIT_OST);
    return STAT_IW'(BIT_WDT);
  endfunction

  function automatic logic [REG_AW-1:0] ctrl_addr(input int unsigned k, input int unsigned nch);
    if (k < nch) return A_CH_BASE + REG_AW'(k);
    if (k == nch) return A_OST_CTRL;
    return A_WDT_CTRL;
  endfunction

  function automatic bit slot_present(input int unsigned k, input int unsigned nch, input bit has_ost);
    return (k < nch) || (k == nch + 1) || ((k == nch) && has_ost);
  endfunction

  // terminal count 4^n - 1, saturating at n = PSC_MAX
  function automatic logic [CNT_W-1:0] div_last(input logic [PSC_W-1:0] psc);
    logic [CNT_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(PSC_MAX); i++) begin
      if (i < int'(psc)) m[2*i +: 2] = 2'b11;
    end
    return m;
  endfunction

endpackage

// File: rtl/tmr_rst_sync.sv
`timescale 1ns/1ps
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/tmr_tick_regs.sv
`timescale 1ns/1ps
module tmr_tick_regs
  import tmr_tick_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter bit          HAS_OST = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [REG_AW-1:0]      addr,
  input  logic [REG_DW-1:0]      wdata,
  output logic [REG_DW-1:0]      rdata,
  output logic [NUM_CH+1:0]      stopped,
  output clk_ctrl_t [NUM_CH+1:0] ctrl,
  output logic [NUM_CH+1:0]      ctrl_load
);

  localparam int unsigned NCLK = NUM_CH + 2;

  logic                  wr_set;
  logic                  wr_clr;
  logic [NCLK-1:0]       stop_q;
  logic [NCLK-1:0]       stop_d;
  clk_ctrl_t [NCLK-1:0]  ctrl_q;
  clk_ctrl_t [NCLK-1:0]  ctrl_d;
  logic [NCLK-1:0]       load;
  logic [NCLK-1:0][REG_DW-1:0] stat_part;
  logic [NCLK-1:0][REG_DW-1:0] rd_part;
  logic [REG_DW-1:0]     rdata_d;
  logic [REG_DW-1:0]     rdata_q;
  logic                  wdata_unused;

  assign wr_set       = wr_en && (addr == A_STOP_SET);
  assign wr_clr       = wr_en && (addr == A_STOP_CLR);
  assign wdata_unused = ^wdata;

  for (genvar k = 0; k < NCLK; k++) begin : g_slot
    localparam logic [STAT_IW-1:0] SB = stop_bit(k, NUM_CH);
    localparam logic [REG_AW-1:0]  CA = ctrl_addr(k, NUM_CH);

    if (slot_present(k, NUM_CH, HAS_OST)) begin : g_live
      assign stop_d[k]    = (wr_set && wdata[SB]) ? 1'b1 :
                            (wr_clr && wdata[SB]) ? 1'b0 : stop_q[k];
      assign load[k]      = wr_en && (addr == CA) && !stop_q[k];
      assign ctrl_d[k]    = load[k] ? clk_ctrl_t'(wdata[CTRL_W-1:0]) : ctrl_q[k];
      assign stat_part[k] = REG_DW'(stop_q[k]) << SB;
      assign rd_part[k]   = (addr == CA) ? REG_DW'(ctrl_q[k]) : '0;

      AST_STOP_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && wdata[SB]) |=> stop_q[k]);                         // R2
      AST_STOP_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && wdata[SB]) |=> !stop_q[k]);                        // R3
      AST_ZERO_BIT_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_set || wr_clr) && !wdata[SB]) |=> $stable(stop_q[k]));   // R3
      AST_STOPPED_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == CA) && stop_q[k]) |=> $stable(ctrl_q[k])); // R6
    end else begin : g_absent
      assign stop_d[k]    = 1'b1;
      assign load[k]      = 1'b0;
      assign ctrl_d[k]    = '0;
      assign stat_part[k] = '0;
      assign rd_part[k]   = '0;
    end
  end

  always_comb begin
    rdata_d = '0;
    if (addr == A_STATUS) begin
      for (int k = 0; k < NCLK; k++) rdata_d = rdata_d | stat_part[k];
    end else begin
      for (int k = 0; k < NCLK; k++) rdata_d = rdata_d | rd_part[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q  <= '1;
      ctrl_q  <= '0;
      rdata_q <= '0;
    end else begin
      stop_q  <= stop_d;
      ctrl_q  <= ctrl_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata     = rdata_q;
  assign stopped   = stop_q;
  assign ctrl      = ctrl_q;
  assign ctrl_load = load;

endmodule

// File: rtl/tmr_tick_div.sv
`timescale 1ns/1ps
module tmr_tick_div
  import tmr_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  clk_ctrl_t        cfg,
  input  logic [PAR_W-1:0] parent_tick,
  output logic             tick_o
);

  logic             sel_tick;
  logic [CNT_W-1:0] last;
  logic             wrap;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             tick_q;
  logic             tick_d;

  // lowest set select bit wins
  always_comb begin
    sel_tick = 1'b0;
    if (cfg.par[0])      sel_tick = parent_tick[0];
    else if (cfg.par[1]) sel_tick = parent_tick[1];
    else if (cfg.par[2]) sel_tick = parent_tick[2];
  end

  assign last = div_last(cfg.psc);
  assign wrap = (cnt_q == last);

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!run || load) begin
      cnt_d = '0;
    end else if (sel_tick) begin
      if (wrap) begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick_q);                                 // R2
  AST_NO_PARENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.par == '0) |=> !tick_q);                      // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);                                    // R5
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((cnt_q == '0) && !tick_q));              // R7
  AST_TICK_FROM_PARENT: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(sel_tick && run));                // R4

endmodule

// File: rtl/tmr_tick_gen.sv
`timescale 1ns/1ps
module tmr_tick_gen
  import tmr_tick_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,  // 6 or 8
  parameter bit          HAS_OST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_pclk,
  input  logic              tick_rtc,
  input  logic              tick_ext,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic [NUM_CH-1:0] tick_ch,
  output logic              tick_ost,
  output logic              tick_wdt
);

  localparam int unsigned NCLK = NUM_CH + 2;

  logic                 rst_n_s;
  logic [NCLK-1:0]      stopped;
  logic [NCLK-1:0]      ctrl_load;
  clk_ctrl_t [NCLK-1:0] ctrl;
  logic [PAR_W-1:0]     parent_tick;
  logic [NCLK-1:0]      tick_all;

  assign parent_tick = {tick_ext, tick_rtc, tick_pclk};

  tmr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  tmr_tick_regs #(
    .NUM_CH  (NUM_CH),
    .HAS_OST (HAS_OST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .stopped   (stopped),
    .ctrl      (ctrl),
    .ctrl_load (ctrl_load)
  );

  for (genvar k = 0; k < NCLK; k++) begin : g_div
    if (slot_present(k, NUM_CH, HAS_OST)) begin : g_on
      tmr_tick_div u_div (
        .clk         (clk),
        .rst_n       (rst_n_s),
        .run         (!stopped[k]),
        .load        (ctrl_load[k]),
        .cfg         (ctrl[k]),
        .parent_tick (parent_tick),
        .tick_o      (tick_all[k])
      );
    end else begin : g_off
      assign tick_all[k] = 1'b0;
    end
  end

  assign tick_ch  = tick_all[NUM_CH-1:0];
  assign tick_ost = tick_all[NUM_CH];
  assign tick_wdt = tick_all[NUM_CH+1];

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (tick_all == '0));                 // R1

endmodule

// File: tb/tmr_tick_gen_test.sv
`timescale 1ns/1ps
module tmr_tick_gen_test;

  localparam int NCH  = 8;
  localparam int NCLK = NCH + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_pclk = 1'b0;
  logic        tick_rtc = 1'b0;
  logic        tick_ext = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  wire  [31:0] reg_rdata;
  wire  [NCH-1:0] tick_ch;
  wire         tick_ost;
  wire         tick_wdt;

  always #5 clk = ~clk;

  tmr_tick_gen #(.NUM_CH(NCH), .HAS_OST(1'b1)) uut (
    .clk(clk), .rst_n(rst_n),
    .tick_pclk(tick_pclk), .tick_rtc(tick_rtc), .tick_ext(tick_ext),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .tick_ch(tick_ch), .tick_ost(tick_ost), .tick_wdt(tick_wdt)
  );

  int n_chk = 0;
  int n_fail = 0;

  // bench model built from the requirements
  bit         m_stop [NCLK];
  logic [5:0] m_ctrl [NCLK];
  int         m_cnt  [NCLK];

  function automatic int spos(int k);
    if (k < NCH) return k;
    if (k == NCH) return 15;
    return 16;
  endfunction

  function automatic logic [4:0] caddr(int k);
    if (k < NCH) return 5'(8 + k);
    if (k == NCH) return 5'd16;
    return 5'd17;
  endfunction

  function automatic int dvm1(logic [2:0] p);
    if (p >= 3'd5) return 1023;
    return (1 << (2 * int'(p))) - 1;
  endfunction

  function automatic bit seltick(logic [2:0] par, logic [2:0] t);
    if (par[0]) return t[0];
    if (par[1]) return t[1];
    if (par[2]) return t[2];
    return 1'b0;
  endfunction

  function automatic logic [31:0] m_read(logic [4:0] a);
    logic [31:0] v;
    v = '0;
    if (a == 5'd0) begin
      for (int k = 0; k < NCLK; k++) if (m_stop[k]) v[spos(k)] = 1'b1;
      return v;
    end
    for (int k = 0; k < NCLK; k++) if (a == caddr(k)) return {26'b0, m_ctrl[k]};
    return v;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // one cycle: drive at negedge, predict, compare at the next negedge
  task automatic cyc(input bit wr, input logic [4:0] a, input logic [31:0] d,
                     input logic [2:0] tk, input string tag);
    logic [31:0]     exp_rd;
    logic [NCLK-1:0] exp_tk;
    reg_wr    = wr;
    reg_addr  = a;
    reg_wdata = d;
    {tick_ext, tick_rtc, tick_pclk} = tk;
    exp_rd = m_read(a);
    for (int k = 0; k < NCLK; k++) begin
      bit run;
      bit hit;
      bit st;
      int last;
      run  = !m_stop[k];
      hit  = wr && (a == caddr(k)) && run;
      st   = seltick(m_ctrl[k][2:0], tk);
      last = dvm1(m_ctrl[k][5:3]);
      exp_tk[k] = run && !hit && st && (m_cnt[k] == last);
      if (!run || hit) m_cnt[k] = 0;
      else if (st) m_cnt[k] = (m_cnt[k] == last) ? 0 : m_cnt[k] + 1;
      if (hit) m_ctrl[k] = d[5:0];
    end
    if (wr && a == 5'd1) for (int k = 0; k < NCLK; k++) if (d[spos(k)]) m_stop[k] = 1'b1;
    if (wr && a == 5'd2) for (int k = 0; k < NCLK; k++) if (d[spos(k)]) m_stop[k] = 1'b0;
    @(negedge clk);
    check(tag, "tick", {22'b0, tick_wdt, tick_ost, tick_ch}, {22'b0, exp_tk});
    check(tag, "rdata", reg_rdata, exp_rd);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, a, d, 3'b000, tag);
  endtask

  task automatic run_ticks(input int n, input logic [2:0] tk, input logic [4:0] a, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, a, 32'h0, tk, tag);
  endtask

  task automatic run_random(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int r;
      int slot;
      logic [2:0] tk;
      logic [2:0] psc;
      logic [31:0] d;
      tk = 3'($urandom % 8);
      if ($urandom % 6 == 0) begin
        r = $urandom % 6;
        d = $urandom;
        if (r == 0) cyc(1'b1, 5'd1, d & 32'h0001_8000 | (d & 32'h0000_00FF & $urandom), tk, tag);
        else if (r <= 2) cyc(1'b1, 5'd2, d, tk, tag);
        else begin
          slot = $urandom % NCLK;
          psc  = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'($urandom % 3);
          cyc(1'b1, caddr(slot), {d[31:6], psc, d[2:0]}, tk, tag);
        end
      end else begin
        r = $urandom % 12;
        cyc(1'b0, (r < 10) ? caddr(r) : ((r == 10) ? 5'd0 : 5'd3), 32'h0, tk, tag);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0A17);
    for (int k = 0; k < NCLK; k++) begin
      m_stop[k] = 1'b1;
      m_ctrl[k] = '0;
      m_cnt[k]  = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    cyc(1'b0, 5'd0, 32'h0, 3'b000, "R1");
    check("R1", "status", reg_rdata, 32'h0001_80FF);
    run_ticks(2, 3'b000, 5'd8, "R1");
    run_ticks(20, 3'b111, 5'd17, "R1");

    // R6: control write to a stopped clock is dropped
    wr(5'd8, 32'h0000_0009, "R6");
    run_ticks(2, 3'b111, 5'd8, "R6");
    check("R6", "ctrl0", reg_rdata, 32'h0);

    // R3: zero writes inert, one bits restart
    wr(5'd2, 32'h0, "R3");
    wr(5'd1, 32'h0, "R3");
    run_ticks(1, 3'b000, 5'd0, "R3");
    check("R3", "status", reg_rdata, 32'h0001_80FF);
    wr(5'd2, 32'h0001_8001, "R3");
    run_ticks(1, 3'b000, 5'd0, "R3");
    check("R3", "status", reg_rdata, 32'h0000_00FE);

    // R9: readback is six bits zero-extended
    wr(5'd8, 32'hFFFF_FFC1, "R9");
    run_ticks(1, 3'b000, 5'd8, "R9");
    check("R9", "ctrl0", reg_rdata, 32'h0000_0001);
    run_ticks(2, 3'b000, 5'd5, "R9");

    // R4: parent selection and priority
    wr(5'd8, 32'h6, "R4");
    run_ticks(10, 3'b100, 5'd8, "R4");
    run_ticks(10, 3'b010, 5'd8, "R4");
    run_ticks(5, 3'b001, 5'd8, "R4");
    wr(5'd8, 32'h4, "R4");
    run_ticks(10, 3'b101, 5'd8, "R4");
    run_ticks(6, 3'b011, 5'd8, "R4");
    wr(5'd8, 32'h7, "R4");
    run_ticks(6, 3'b110, 5'd8, "R4");
    run_ticks(6, 3'b001, 5'd8, "R4");

    // R5: every prescale value on a steady parent
    for (int p = 0; p < 8; p++) begin
      wr(5'd8, 32'((p << 3) | 1), "R5");
      run_ticks((p >= 5) ? 1100 : (2 * (1 << (2 * p)) + 5), 3'b001, 5'd8, "R5");
    end
    wr(5'd8, 32'h0000_000C, "R5");
    for (int i = 0; i < 200; i++) cyc(1'b0, 5'd8, 32'h0, 3'($urandom % 8), "R5");

    // R7: divider cleared by control write and by restart
    wr(5'd8, 32'h0000_0011, "R7");
    run_ticks(10, 3'b001, 5'd8, "R7");
    cyc(1'b1, 5'd8, 32'h0000_0011, 3'b001, "R7");
    run_ticks(20, 3'b001, 5'd8, "R7");
    wr(5'd1, 32'h1, "R7");
    run_ticks(5, 3'b001, 5'd8, "R7");
    wr(5'd2, 32'h1, "R7");
    run_ticks(20, 3'b001, 5'd8, "R7");

    // R8: no parent selected
    wr(5'd8, 32'h0000_0018, "R8");
    run_ticks(30, 3'b111, 5'd8, "R8");

    // R2: stopping channel 0, OS timer and watchdog
    wr(5'd8, 32'h1, "R2");
    run_ticks(4, 3'b001, 5'd0, "R2");
    wr(5'd1, 32'h1, "R2");
    run_ticks(8, 3'b111, 5'd0, "R2");
    wr(5'd16, 32'h1, "R2");
    run_ticks(4, 3'b001, 5'd16, "R2");
    wr(5'd1, 32'h0000_8000, "R2");
    run_ticks(4, 3'b001, 5'd0, "R2");
    check("R2", "status", reg_rdata, 32'h0000_80FF);
    wr(5'd17, 32'h2, "R2");
    run_ticks(4, 3'b010, 5'd17, "R2");
    wr(5'd1, 32'h0001_0000, "R2");
    run_ticks(4, 3'b010, 5'd0, "R2");
    check("R2", "status", reg_rdata, 32'h0001_80FF);

    // seeded random mix over all requirements' mechanisms (R4, R5, R7)
    run_random(20000, "R5");
    finish_run();
  end

endmodule